// File: doc/BRIEF.md
# MESI Coherence State Controller

This block keeps the coherence state of every line of one private, direct-mapped cache that sits on a snooping shared bus. Each line holds one of four states: Modified, Exclusive, Shared or Invalid. The block also keeps a tag for each line. Data storage and replacement policy are outside the block.

Two kinds of event drive the block. Local processor reads and writes arrive on the processor port. Reads and writes seen on the shared bus, issued by other caches, arrive on the snoop port.

For each event the block does three things:
- It picks the line's next state.
- It decides whether a bus transaction is needed, and of which kind.
- It decides whether a dirty line must first be written back.

A processor request stays asserted until it is acknowledged. A snooped transaction is held off, and the requester presents it again, while a writeback is in flight.

Top module: `mesi_coherence_ctl`

## Requirements
- R1: Synchronous active-high reset leaves every line Invalid. In the first cycle after reset, every output is low. The first request to any line is therefore a miss.
- R2: A read miss requests the bus with `bus_cmd` = 2'b01. In the cycle `bus_gnt` is high, `bus_shared_in` is sampled. The line becomes Shared if `bus_shared_in` is 1 and Exclusive if it is 0. `cpu_ack` is high in that same grant cycle.
- R3: A read that hits a line in Modified, Exclusive or Shared is acknowledged in the cycle it is presented. It raises no `bus_req` and leaves the state unchanged.
- R4: A write that hits Modified or Exclusive is acknowledged in the cycle it is presented, with no `bus_req`. The line ends Modified.
- R5: A write that hits Shared requests the bus with `bus_cmd` = 2'b11 (invalidate other copies). On grant it is acknowledged and the line becomes Modified.
- R6: A write that misses requests the bus with `bus_cmd` = 2'b10 (read-for-ownership). On grant the line becomes Modified. `bus_cmd` is 2'b00 whenever `bus_req` is low.
- R7: A snooped read (`snp_write` = 0) that matches a valid line drives `snp_shared_out` high in that cycle. A matching Exclusive line becomes Shared. A snoop that does not match drives `snp_shared_out` low and changes nothing.
- R8: A snooped write or read-for-ownership (`snp_write` = 1) that matches a Shared or Exclusive line makes it Invalid, with no hold.
- R9: A snoop that matches a Modified line raises `snp_hold` in that cycle. From the next cycle `wb_req` stays high with `wb_addr` equal to the snooped address until `wb_done`. While `wb_req` is high, `snp_hold` stays high and snoops are ignored. On `wb_done` the line becomes Shared for a read snoop and Invalid for a write snoop.
- R10: A miss whose direct-mapped slot holds a Modified line with a different tag first writes the victim back. `wb_addr` = {old tag, index}. Only after `wb_done` is the bus requested. A clean victim is replaced without a writeback.
- R11: When `snp_valid` is high, no local request is acknowledged or sent to the bus in that cycle. The snoop is applied first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present, held until `cpu_ack` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address; low bits index, high bits tag |
| cpu_ack | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction requested for the processor request |
| bus_cmd | output | 2 | 01 read, 10 read-for-ownership, 11 upgrade, 00 none |
| bus_addr | output | ADDR_W | Address of the bus transaction |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled on grant) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_write | input | 1 | 1 = write or read-for-ownership, 0 = read |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared_out | output | 1 | This cache holds the snooped line (read snoops) |
| snp_hold | output | 1 | Snooped transaction must wait and be presented again |
| wb_req | output | 1 | Dirty-line writeback in progress |
| wb_addr | output | ADDR_W | Address of the line being written back |
| wb_done | input | 1 | Writeback finished |

## Verification
Processor requests are run against lines in every state:
- fresh misses, with the shared response both asserted and deasserted;
- hits on clean and on dirty lines;
- conflicting tags in one slot, with clean and with dirty victims.

These separate the three bus commands and show Exclusive and Shared apart through the command a later write issues.

Snoops cover matching and non-matching addresses, read and write kinds, and dirty targets. These separate a downgrade from an invalidate and show the hold-and-writeback sequence.

A processor request and a snoop presented in the same cycle show which one is applied first. A behavioural model checks every output on every clock.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'b00,
        BC_READ = 2'b01,
        BC_RFO  = 2'b10,
        BC_UPGR = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        WB_SNP_RD = 2'b00,
        WB_SNP_WR = 2'b01,
        WB_EVICT  = 2'b10
    } wb_cause_e;

    // Decision for the processor request.
    typedef struct packed {
        logic        ack;
        logic        bus;
        bus_cmd_e    cmd;
        logic        evict;
        line_state_e nst;
    } cpu_dec_t;

    // Decision for the snooped transaction.
    typedef struct packed {
        logic        hit;
        logic        shared;
        logic        dirty;
        logic        upd;
        line_state_e nst;
    } snp_dec_t;

    // State reached by a line when its bus transaction is granted.
    function automatic line_state_e fill_state(logic is_write, logic others_have);
        if (is_write)    return ST_M;
        if (others_have) return ST_S;
        return ST_E;
    endfunction

    // State reached by a line once its writeback completes.
    function automatic line_state_e after_wb(wb_cause_e cause);
        return (cause == WB_SNP_RD) ? ST_S : ST_I;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int TAG_W  = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(NLINES)-1:0]  wr_idx,
    input  line_state_e                wr_st,
    input  logic [TAG_W-1:0]           wr_tag,
    output line_state_e                st_q  [NLINES],
    output logic [TAG_W-1:0]           tag_q [NLINES]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NLINES; i++) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]  <= wr_st;
            tag_q[wr_idx] <= wr_tag;
        end
    end

endmodule

// File: rtl/mesi_cpu_ctl.sv
module mesi_cpu_ctl
    import mesi_pkg::*;
#(
    parameter int TAG_W = 7
) (
    input  logic              en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [TAG_W-1:0]  req_tag,
    input  line_state_e       cur_st,
    input  logic [TAG_W-1:0]  cur_tag,
    input  logic              gnt,
    input  logic              shared_in,
    output cpu_dec_t          dec
);

    logic hit;
    logic owned;

    assign hit   = (cur_st != ST_I) && (cur_tag == req_tag);
    assign owned = (cur_st == ST_M) || (cur_st == ST_E);

    always_comb begin
        dec       = '0;
        dec.cmd   = BC_NONE;
        dec.nst   = cur_st;
        if (en && req_valid) begin
            if (hit && (!req_write || owned)) begin
                dec.ack = 1'b1;
                dec.nst = req_write ? ST_M : cur_st;
            end else if (!hit && cur_st == ST_M) begin
                dec.evict = 1'b1;
            end else begin
                dec.bus = 1'b1;
                if (!req_write)  dec.cmd = BC_READ;
                else if (hit)    dec.cmd = BC_UPGR;
                else             dec.cmd = BC_RFO;
                if (gnt) begin
                    dec.ack = 1'b1;
                    dec.nst = fill_state(req_write, shared_in);
                end
            end
        end
    end

endmodule

// File: rtl/mesi_snoop_ctl.sv
module mesi_snoop_ctl
    import mesi_pkg::*;
#(
    parameter int TAG_W = 7
) (
    input  logic              en,
    input  logic              snp_write,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_state_e       cur_st,
    input  logic [TAG_W-1:0]  cur_tag,
    output snp_dec_t          dec
);

    always_comb begin
        dec        = '0;
        dec.nst    = cur_st;
        dec.hit    = en && (cur_st != ST_I) && (cur_tag == snp_tag);
        dec.shared = dec.hit && !snp_write;
        dec.dirty  = dec.hit && (cur_st == ST_M);
        dec.upd    = dec.hit && !dec.dirty;
        if (dec.upd) dec.nst = snp_write ? ST_I : ST_S;
    end

endmodule

// File: rtl/mesi_coherence_ctl.sv
module mesi_coherence_ctl
    import mesi_pkg::*;
#(
    parameter int NLINES = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ack,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared_out,
    output logic              snp_hold,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_done
);

    localparam int IDX_W = $clog2(NLINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] cpu_idx, snp_idx, wbq_idx, w_idx;
    logic [TAG_W-1:0] cpu_tag, snp_tag, wbq_tag, w_tag;
    line_state_e      line_st  [NLINES];
    logic [TAG_W-1:0] line_tag [NLINES];
    line_state_e      w_st;
    logic             w_en;

    logic              wb_busy;
    logic [ADDR_W-1:0] wb_addr_q;
    wb_cause_e         wb_cause_q;

    cpu_dec_t cd;
    snp_dec_t sd;
    logic     cpu_en, snp_en;

    assign cpu_idx = cpu_addr[IDX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign wbq_idx = wb_addr_q[IDX_W-1:0];
    assign wbq_tag = wb_addr_q[ADDR_W-1:IDX_W];

    // Snoops take priority over the processor; both wait out a writeback.
    assign snp_en = !wb_busy && snp_valid;
    assign cpu_en = !wb_busy && !snp_valid;

    mesi_line_store #(.NLINES(NLINES), .TAG_W(TAG_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (w_en),
        .wr_idx (w_idx),
        .wr_st  (w_st),
        .wr_tag (w_tag),
        .st_q   (line_st),
        .tag_q  (line_tag)
    );

    mesi_cpu_ctl #(.TAG_W(TAG_W)) u_cpu (
        .en        (cpu_en),
        .req_valid (cpu_valid),
        .req_write (cpu_write),
        .req_tag   (cpu_tag),
        .cur_st    (line_st[cpu_idx]),
        .cur_tag   (line_tag[cpu_idx]),
        .gnt       (bus_gnt),
        .shared_in (bus_shared_in),
        .dec       (cd)
    );

    mesi_snoop_ctl #(.TAG_W(TAG_W)) u_snp (
        .en        (snp_en),
        .snp_write (snp_write),
        .snp_tag   (snp_tag),
        .cur_st    (line_st[snp_idx]),
        .cur_tag   (line_tag[snp_idx]),
        .dec       (sd)
    );

    // Single write port into the line store.
    always_comb begin
        w_en  = 1'b0;
        w_idx = cpu_idx;
        w_st  = cd.nst;
        w_tag = cpu_tag;
        if (wb_busy) begin
            w_en  = wb_done;
            w_idx = wbq_idx;
            w_st  = after_wb(wb_cause_q);
            w_tag = wbq_tag;
        end else if (snp_valid) begin
            w_en  = sd.upd;
            w_idx = snp_idx;
            w_st  = sd.nst;
            w_tag = snp_tag;
        end else begin
            w_en  = cd.ack;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_busy    <= 1'b0;
            wb_addr_q  <= '0;
            wb_cause_q <= WB_EVICT;
        end else if (wb_busy) begin
            if (wb_done) wb_busy <= 1'b0;
        end else if (sd.dirty) begin
            wb_busy    <= 1'b1;
            wb_addr_q  <= snp_addr;
            wb_cause_q <= snp_write ? WB_SNP_WR : WB_SNP_RD;
        end else if (cd.evict) begin
            wb_busy    <= 1'b1;
            wb_addr_q  <= {line_tag[cpu_idx], cpu_idx};
            wb_cause_q <= WB_EVICT;
        end
    end

    assign cpu_ack        = cd.ack;
    assign bus_req        = cd.bus;
    assign bus_cmd        = cd.cmd;
    assign bus_addr       = cpu_addr;
    assign snp_shared_out = sd.shared;
    assign snp_hold       = wb_busy || sd.dirty;
    assign wb_req         = wb_busy;
    assign wb_addr        = wb_addr_q;

    // ---------------- assertions ----------------
    for (genvar gi = 0; gi < NLINES; gi++) begin : g_rst_chk
        a_r1_reset_invalid: assert property (@(posedge clk)
            rst |=> line_st[gi] == ST_I);
    end

    a_r2_fill_follows_shared: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && bus_req && !cpu_write)
        |=> line_st[$past(cpu_idx)] == ($past(bus_shared_in) ? ST_S : ST_E));

    a_r4_write_ends_modified: assert property (@(posedge clk) disable iff (rst)
        (cpu_ack && cpu_write) |=> line_st[$past(cpu_idx)] == ST_M);

    a_r7_snoop_read_downgrades: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && !snp_write && snp_shared_out && !snp_hold)
        |=> line_st[$past(snp_idx)] == ST_S);

    a_r8_snoop_write_clears: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_write && !snp_hold)
        |=> (line_st[$past(snp_idx)] == ST_I) || (line_tag[$past(snp_idx)] != $past(snp_tag)));

    a_r9_hold_during_wb: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> snp_hold);

    a_r9_dirty_snoop_starts_wb: assert property (@(posedge clk) disable iff (rst)
        (snp_hold && !wb_req) |=> wb_req);

    a_r11_snoop_blocks_cpu: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> (!cpu_ack && !bus_req));

endmodule

// File: tb/mesi_coherence_ctl_tb.sv
module mesi_coherence_ctl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N  = 8;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_valid, cpu_write, cpu_ack;
    logic [AW-1:0] cpu_addr, bus_addr, snp_addr, wb_addr;
    logic          bus_req, bus_gnt, bus_shared_in;
    logic [1:0]    bus_cmd;
    logic          snp_valid, snp_write, snp_shared_out, snp_hold;
    logic          wb_req, wb_done;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mesi_coherence_ctl #(.NLINES(N), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_ack(cpu_ack),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
        .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .snp_shared_out(snp_shared_out), .snp_hold(snp_hold),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_done(wb_done)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // ---------------- reference model (0 I, 1 S, 2 E, 3 M) ----------------
    int mst [N];
    int mtag[N];
    bit mwb;
    int mwb_addr, mwb_cause;   // cause: 1 snoop read, 2 snoop write, 3 evict

    always @(negedge clk) begin
        int  i, t, e_cmd, e_wba;
        bit  hit, e_ack, e_breq, e_sh, e_hold, e_wb;
        if (rst) begin
            for (int k = 0; k < N; k++) begin mst[k] = 0; mtag[k] = 0; end
            mwb = 0;
        end else begin
            e_ack = 0; e_breq = 0; e_sh = 0; e_hold = 0; e_wb = 0; e_cmd = 0;
            e_wba = mwb_addr;
            if (mwb) begin
                e_hold = 1; e_wb = 1;
                if (wb_done) begin
                    i = mwb_addr % N;
                    mst[i]  = (mwb_cause == 1) ? 1 : 0;
                    mtag[i] = mwb_addr / N;
                    mwb = 0;
                end
            end else if (snp_valid) begin
                i = snp_addr % N; t = snp_addr / N;
                hit = (mst[i] != 0) && (mtag[i] == t);
                e_sh   = hit && !snp_write;
                e_hold = hit && (mst[i] == 3);
                if (e_hold) begin
                    mwb = 1; mwb_addr = snp_addr; mwb_cause = snp_write ? 2 : 1;
                end else if (hit) begin
                    mst[i] = snp_write ? 0 : 1;
                end
            end else if (cpu_valid) begin
                i = cpu_addr % N; t = cpu_addr / N;
                hit = (mst[i] != 0) && (mtag[i] == t);
                if (hit && (!cpu_write || mst[i] >= 2)) begin
                    e_ack = 1;
                    if (cpu_write) mst[i] = 3;
                end else if (!hit && mst[i] == 3) begin
                    mwb = 1; mwb_addr = mtag[i] * N + i; mwb_cause = 3;
                end else begin
                    e_breq = 1;
                    e_cmd  = !cpu_write ? 1 : (hit ? 3 : 2);
                    if (bus_gnt) begin
                        e_ack   = 1;
                        mst[i]  = cpu_write ? 3 : (bus_shared_in ? 1 : 2);
                        mtag[i] = t;
                    end
                end
            end
            chk(cpu_ack === e_ack,         "R3",  "model cpu_ack",   int'(cpu_ack), int'(e_ack));
            chk(bus_req === e_breq,        "R6",  "model bus_req",   int'(bus_req), int'(e_breq));
            chk(bus_cmd === 2'(e_cmd),     "R6",  "model bus_cmd",   int'(bus_cmd), e_cmd);
            chk(snp_shared_out === e_sh,   "R7",  "model shared",    int'(snp_shared_out), int'(e_sh));
            chk(snp_hold === e_hold,       "R9",  "model snp_hold",  int'(snp_hold), int'(e_hold));
            chk(wb_req === e_wb,           "R9",  "model wb_req",    int'(wb_req), int'(e_wb));
            if (e_wb) chk(int'(wb_addr) == e_wba, "R10", "model wb_addr", int'(wb_addr), e_wba);
        end
    end

    // ---------------- writeback responder ----------------
    int wb_age = 0;
    initial begin
        wb_done = 0;
        forever begin
            @(negedge clk);
            wb_age = wb_req ? wb_age + 1 : 0;
            @(posedge clk); #2;
            wb_done = (wb_age == 2);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic cpu_op(bit w, int a, bit sh, int gdly,
                          output bit saw_bus, output int cmd, output bit saw_wb, output int wba);
        int  cyc = 0;
        bit  done = 0;
        saw_bus = 0; cmd = 0; saw_wb = 0; wba = -1;
        @(posedge clk); #2;
        cpu_valid = 1; cpu_write = w; cpu_addr = AW'(a); bus_shared_in = sh; bus_gnt = (gdly == 0);
        while (!done) begin
            @(negedge clk);
            if (bus_req) begin saw_bus = 1; cmd = int'(bus_cmd); end
            if (wb_req && !saw_wb) begin saw_wb = 1; wba = int'(wb_addr); end
            if (bus_req && !saw_wb && wba == -1) wba = -2;
            done = cpu_ack;
            cyc++;
            @(posedge clk); #2;
            bus_gnt = (cyc >= gdly);
        end
        cpu_valid = 0; bus_gnt = 0; bus_shared_in = 0;
    endtask

    task automatic snoop(bit w, int a, output bit saw_hold, output bit sh_final,
                         output bit saw_wb, output int wba);
        bit done = 0;
        saw_hold = 0; sh_final = 0; saw_wb = 0; wba = -1;
        @(posedge clk); #2;
        snp_valid = 1; snp_write = w; snp_addr = AW'(a);
        while (!done) begin
            @(negedge clk);
            if (wb_req && !saw_wb) begin saw_wb = 1; wba = int'(wb_addr); end
            if (snp_hold) saw_hold = 1;
            else begin sh_final = snp_shared_out; done = 1; end
        end
        @(posedge clk); #2;
        snp_valid = 0;
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    localparam int A  = 'h011;  // index 1
    localparam int B  = 'h019;  // index 1, other tag
    localparam int C  = 'h022;
    localparam int D  = 'h033;
    localparam int F  = 'h044;
    localparam int G  = 'h055;

    initial begin
        bit sb, sw, sh, hold;
        int cmd, wba;
        rst = 1; cpu_valid = 0; cpu_write = 0; cpu_addr = '0; bus_gnt = 0; bus_shared_in = 0;
        snp_valid = 0; snp_write = 0; snp_addr = '0;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        @(negedge clk);
        chk(!cpu_ack && !bus_req && !wb_req && !snp_hold && !snp_shared_out && bus_cmd == 2'b00,
            "R1", "outputs low after reset", int'(bus_req), 0);

        // R1/R2: first read misses; no shared response -> Exclusive
        cpu_op(0, A, 0, 1, sb, cmd, sw, wba);
        chk(sb && cmd == 1, "R1", "reset line misses with read cmd", cmd, 1);
        // R4: write hit on Exclusive is local
        cpu_op(1, A, 0, 0, sb, cmd, sw, wba);
        chk(!sb, "R2", "exclusive fill -> local write", int'(sb), 0);
        cpu_op(1, A, 0, 0, sb, cmd, sw, wba);
        chk(!sb, "R4", "write hit on modified local", int'(sb), 0);
        // R3: read hit no bus
        cpu_op(0, A, 0, 0, sb, cmd, sw, wba);
        chk(!sb, "R3", "read hit on modified no bus", int'(sb), 0);

        // R9: snoop read on Modified -> hold, writeback, then Shared
        snoop(0, A, hold, sh, sw, wba);
        chk(hold && sw && wba == A, "R9", "dirty snoop writeback addr", wba, A);
        chk(sh, "R7", "re-presented snoop sees shared", int'(sh), 1);
        // R5: write hit on Shared -> upgrade
        cpu_op(1, A, 0, 2, sb, cmd, sw, wba);
        chk(sb && cmd == 3, "R5", "shared write issues upgrade", cmd, 3);

        // R9: snoop write on Modified -> writeback then Invalid
        snoop(1, A, hold, sh, sw, wba);
        chk(hold && sw && wba == A, "R9", "dirty snoop-write writeback", wba, A);
        cpu_op(0, A, 1, 1, sb, cmd, sw, wba);
        chk(sb && cmd == 1, "R8", "invalidated line misses", cmd, 1);
        cpu_op(1, A, 0, 0, sb, cmd, sw, wba);
        chk(sb && cmd == 3, "R2", "shared response -> Shared fill", cmd, 3);

        // R10: dirty victim written back before the fill
        cpu_op(0, B, 0, 0, sb, cmd, sw, wba);
        chk(sw && wba == A, "R10", "dirty victim address", wba, A);
        chk(sb && cmd == 1, "R10", "fill after writeback", cmd, 1);
        cpu_op(0, A, 0, 0, sb, cmd, sw, wba);
        chk(!sw && sb, "R10", "clean victim no writeback", int'(sw), 0);

        // R7/R8: snoops that miss; Shared invalidated
        snoop(0, D, hold, sh, sw, wba);
        chk(!hold && !sh, "R7", "snoop miss not shared", int'(sh), 0);
        cpu_op(0, D, 1, 0, sb, cmd, sw, wba);
        snoop(1, D, hold, sh, sw, wba);
        chk(!hold && !sw, "R8", "snoop write on shared no hold", int'(hold), 0);
        cpu_op(0, D, 0, 0, sb, cmd, sw, wba);
        chk(sb && cmd == 1, "R8", "shared line invalidated", cmd, 1);
        snoop(0, C, hold, sh, sw, wba);
        chk(!sh, "R7", "snoop on empty slot", int'(sh), 0);

        // R6: write miss -> read-for-ownership, then read hit
        cpu_op(1, F, 0, 3, sb, cmd, sw, wba);
        chk(sb && cmd == 2, "R6", "write miss rfo cmd", cmd, 2);
        cpu_op(0, F, 0, 0, sb, cmd, sw, wba);
        chk(!sb, "R3", "read after rfo hits", int'(sb), 0);

        // R11: snoop and local write to the same Exclusive line together
        cpu_op(0, G, 0, 0, sb, cmd, sw, wba);
        @(posedge clk); #2;
        cpu_valid = 1; cpu_write = 1; cpu_addr = AW'(G);
        snp_valid = 1; snp_write = 0; snp_addr = AW'(G);
        @(negedge clk);
        chk(!cpu_ack && !bus_req, "R11", "cpu blocked by snoop", int'(cpu_ack), 0);
        chk(snp_shared_out, "R11", "snoop served first", int'(snp_shared_out), 1);
        @(posedge clk); #2;
        snp_valid = 0; bus_gnt = 1;
        @(negedge clk);
        chk(bus_req && bus_cmd == 2'b11 && cpu_ack, "R11", "write sees downgraded line",
            int'(bus_cmd), 3);
        @(posedge clk); #2;
        cpu_valid = 0; bus_gnt = 0;
        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule